// File: doc/BRIEF.md
# Watermark-Driven Transmit Frame FIFO

This block is a byte-wide transmit buffer. A host fills it one byte at a time and tags the last byte of each frame. A serializing transmitter drains it from the other side. A registered request output tells the host when enough room is free to accept another burst. The host picks the size of that burst from three thresholds.

The block remembers where the frame currently being sent begins. While fewer than 56 of that frame's bytes have left the buffer, its bytes are held. Together with an 8-byte preamble, 56 bytes make the 64-byte collision window. During that window the transmitter may ask to start the frame again, so free space is counted from the frame start. Once the window has passed, a restart is no longer possible, and space is counted from the live read position. When the transmitter reports the frame finished, the frame-start marker moves to the next unread byte.

Top module: `tx_wm_fifo`

## Requirements
- R1: While `rst_n` is low, `rd_valid`, `ovf` and `dreq` are 0 and the buffer is empty. After release, with 128 bytes free, `dreq` is 1 from the first clock edge on.
- R2: The threshold is selected by `thr_sel`: 2'b00 selects 64 bytes, 2'b01 selects 32, 2'b10 selects 16, and 2'b11 selects 64. The default selection of zero therefore gives 64. `dreq` is 1 exactly when the free count is greater than or equal to the selected threshold.
- R3: Bytes and their end-of-frame tags come out on `rd_data`/`rd_eof` in write order. `rd_valid` is 0 when no unread byte remains, and a read while `rd_valid` is 0 has no effect.
- R4: A write while all 128 entries are held is ignored, and it sets `ovf`. `ovf` stays at 1 until reset.
- R5: While fewer than 56 bytes of the current frame have been read, the free count is 128 minus the bytes between the frame-start marker and the write position.
- R6: From the 56th read of the current frame on, the free count is 128 minus the bytes between the live read position and the write position.
- R7: `frame_retry` while fewer than 56 bytes of the frame have been read moves the read position back to the frame start, and the window count restarts.
- R8: `frame_retry` after 56 or more bytes of the frame have been read has no effect.
- R9: `frame_done` moves the frame-start marker to the current read position and clears the window count, which releases the frame's bytes.
- R10: Writing the end-of-frame tag does not change `dreq`. `dreq` stays 1 after a whole frame is loaded, as long as the free count meets the threshold.
- R11: `dreq` follows a pointer change or a `thr_sel` change with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| wr_eof | input | 1 | Marks the written byte as the last byte of a frame |
| rd_en | input | 1 | Transmitter read strobe |
| rd_data | output | 8 | Byte at the read position |
| rd_eof | output | 1 | End-of-frame tag of the byte at the read position |
| rd_valid | output | 1 | An unread byte is present |
| frame_done | input | 1 | Transmitter finished the current frame |
| frame_retry | input | 1 | Transmitter restarts the current frame |
| thr_sel | input | 2 | Free-space threshold selection |
| dreq | output | 1 | Registered request for more host data |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The checker assumes that the transmitter raises at most one of `rd_en`, `frame_done` and `frame_retry` in any cycle. It also assumes `frame_done` follows only the reads of the frame it closes. The block resolves overlaps by giving retry priority over done, and done priority over read. The retry and done properties are written for the single-strobe case. The bench drives each strobe for exactly one clock, with idle cycles between strobes, and never overlaps them. Host writes stay independent of the transmitter strobes, and the bench only writes while no strobe is active.

// File: rtl/txf_pkg.sv
package txf_pkg;

   typedef enum logic [1:0] {
      THR_SEL_HI  = 2'b00,
      THR_SEL_MID = 2'b01,
      THR_SEL_LO  = 2'b10,
      THR_SEL_ALT = 2'b11
   } thr_sel_e;

   // Map a selection code onto a threshold in bytes.
   function automatic int unsigned thr_decode(input logic [1:0] sel,
                                              input int unsigned lo,
                                              input int unsigned mid,
                                              input int unsigned hi);
      case (thr_sel_e'(sel))
         THR_SEL_MID: return mid;
         THR_SEL_LO:  return lo;
         default:     return hi;
      endcase
   endfunction

endpackage

// File: rtl/txf_mem.sv
module txf_mem #(
   parameter int DW    = 8,
   parameter int DEPTH = 128,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_fire,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW:0]   wr_word,
   input  logic [AW-1:0] rd_addr,
   output logic [DW:0]   rd_word
);
   logic [DW:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_fire) store[wr_addr] <= wr_word;
   end

   assign rd_word = store[rd_addr];
endmodule

// File: rtl/txf_ptrs.sv
module txf_ptrs #(
   parameter int DEPTH = 128,
   parameter int AW    = $clog2(DEPTH),
   parameter int WIN   = 56
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic        frame_done,
   input  logic        frame_retry,
   input  logic        full,
   output logic [AW:0] wr_ptr,
   output logic [AW:0] rd_ptr,
   output logic [AW:0] sav_ptr,
   output logic        committed,
   output logic        empty,
   output logic        wr_fire,
   output logic        ovf
);
   localparam int CW = $clog2(WIN + 1);

   logic [CW-1:0] frm_cnt;
   logic          rd_fire;

   assign empty     = (rd_ptr == wr_ptr);
   assign committed = (frm_cnt == CW'(WIN));
   assign wr_fire   = wr_en && !full;
   assign rd_fire   = rd_en && !empty && !frame_done && !frame_retry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         ovf    <= 1'b0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   // Retry wins over done, done wins over read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         sav_ptr <= '0;
         frm_cnt <= '0;
      end else if (frame_retry) begin
         if (!committed) begin
            rd_ptr  <= sav_ptr;
            frm_cnt <= '0;
         end
      end else if (frame_done) begin
         sav_ptr <= rd_ptr;
         frm_cnt <= '0;
      end else if (rd_fire) begin
         rd_ptr <= rd_ptr + 1'b1;
         if (!committed) frm_cnt <= frm_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/txf_space.sv
module txf_space
   import txf_pkg::*;
#(
   parameter int DEPTH   = 128,
   parameter int AW      = $clog2(DEPTH),
   parameter int THR_LO  = 16,
   parameter int THR_MID = 32,
   parameter int THR_HI  = 64,
   parameter bit REG_REQ = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [AW:0] wr_ptr,
   input  logic [AW:0] rd_ptr,
   input  logic [AW:0] sav_ptr,
   input  logic        committed,
   input  logic [1:0]  thr_sel,
   output logic [AW:0] free_cnt,
   output logic        full,
   output logic        dreq
);
   logic [AW:0] base;
   logic [AW:0] used;
   logic [AW:0] thr;
   logic        meets;

   assign base     = committed ? rd_ptr : sav_ptr;
   assign used     = wr_ptr - base;
   assign free_cnt = (AW+1)'(DEPTH) - used;
   assign full     = (used == (AW+1)'(DEPTH));
   assign thr      = (AW+1)'(thr_decode(thr_sel, THR_LO, THR_MID, THR_HI));
   assign meets    = (free_cnt >= thr);

   generate
      if (REG_REQ) begin : g_req_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dreq <= 1'b0;
            else        dreq <= meets;
         end
      end else begin : g_req_comb
         assign dreq = meets && rst_n;
      end
   endgenerate
endmodule

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo #(
   parameter int DW             = 8,
   parameter int DEPTH          = 128,
   parameter int THR_LO         = 16,
   parameter int THR_MID        = 32,
   parameter int THR_HI         = 64,
   parameter int MIN_TX_BYTES   = 64,
   parameter int PREAMBLE_BYTES = 8,
   parameter bit REG_REQ        = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_eof,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_eof,
   output logic          rd_valid,
   input  logic          frame_done,
   input  logic          frame_retry,
   input  logic [1:0]    thr_sel,
   output logic          dreq,
   output logic          ovf
);
   localparam int AW  = $clog2(DEPTH);
   localparam int WIN = MIN_TX_BYTES - PREAMBLE_BYTES;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (!(THR_LO < THR_MID && THR_MID < THR_HI && THR_HI <= DEPTH)) begin : g_bad_thr
         $error("thresholds must ascend and fit in DEPTH");
      end
      if (WIN < 1 || WIN >= DEPTH) begin : g_bad_win
         $error("window must lie between 1 and DEPTH-1 bytes");
      end
   endgenerate

   logic [AW:0] wr_ptr, rd_ptr, sav_ptr, free_cnt;
   logic        committed, empty, full, wr_fire;
   logic [DW:0] rd_word;

   txf_ptrs #(.DEPTH(DEPTH), .AW(AW), .WIN(WIN)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .frame_done(frame_done), .frame_retry(frame_retry), .full(full),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .sav_ptr(sav_ptr),
      .committed(committed), .empty(empty), .wr_fire(wr_fire), .ovf(ovf)
   );

   txf_space #(.DEPTH(DEPTH), .AW(AW), .THR_LO(THR_LO), .THR_MID(THR_MID),
               .THR_HI(THR_HI), .REG_REQ(REG_REQ)) u_space (
      .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .sav_ptr(sav_ptr), .committed(committed), .thr_sel(thr_sel),
      .free_cnt(free_cnt), .full(full), .dreq(dreq)
   );

   txf_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .wr_fire(wr_fire), .wr_addr(wr_ptr[AW-1:0]),
      .wr_word({wr_eof, wr_data}), .rd_addr(rd_ptr[AW-1:0]), .rd_word(rd_word)
   );

   assign rd_data  = rd_word[DW-1:0];
   assign rd_eof   = rd_word[DW];
   assign rd_valid = !empty;
endmodule

// File: rtl/tx_wm_fifo_chk.sv
module tx_wm_fifo_chk
   import txf_pkg::*;
#(
   parameter int DEPTH   = 128,
   parameter int AW      = $clog2(DEPTH),
   parameter int THR_LO  = 16,
   parameter int THR_MID = 32,
   parameter int THR_HI  = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        rd_en,
   input logic        rd_valid,
   input logic        frame_done,
   input logic        frame_retry,
   input logic [1:0]  thr_sel,
   input logic        dreq,
   input logic        ovf,
   input logic        full,
   input logic        committed,
   input logic [AW:0] wr_ptr,
   input logic [AW:0] rd_ptr,
   input logic [AW:0] sav_ptr,
   input logic [AW:0] free_cnt
);
   logic [AW:0] thr_c;
   assign thr_c = (AW+1)'(thr_decode(thr_sel, THR_LO, THR_MID, THR_HI));

   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> (ovf && $stable(wr_ptr)));
   assert_free_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= (AW+1)'(DEPTH));
   assert_no_read_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_valid && !frame_retry) |=> $stable(rd_ptr));
   assert_req_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (dreq == $past(free_cnt >= thr_c)));
   assert_retry_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_retry && !committed) |=> (rd_ptr == $past(sav_ptr)));
   assert_retry_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_retry && committed) |=> $stable(rd_ptr));
   assert_done_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_retry) |=> (sav_ptr == $past(rd_ptr) && !committed));
endmodule

bind tx_wm_fifo tx_wm_fifo_chk #(
   .DEPTH(DEPTH), .AW(AW), .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
   .frame_done(frame_done), .frame_retry(frame_retry), .thr_sel(thr_sel),
   .dreq(dreq), .ovf(ovf), .full(full), .committed(committed),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .sav_ptr(sav_ptr), .free_cnt(free_cnt)
);

// File: tb/tb_tx_wm_fifo.sv
`timescale 1ns/1ps
module tb_tx_wm_fifo;
   localparam int DEPTH = 128;
   localparam int WIN   = 56;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       frame_done = 1'b0, frame_retry = 1'b0;
   logic [1:0] thr_sel = 2'b00;
   logic [7:0] rd_data;
   logic       rd_eof, rd_valid, dreq, ovf;

   always #5 clk = ~clk;

   tx_wm_fifo dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
      .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof), .rd_valid(rd_valid),
      .frame_done(frame_done), .frame_retry(frame_retry), .thr_sel(thr_sel),
      .dreq(dreq), .ovf(ovf)
   );

   int n_run = 0, n_fail = 0;
   bit done_flag = 0;
   logic [8:0] sb [0:1023];
   int m_wp = 0, m_rp = 0, m_sp = 0, m_fc = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int thr_of(input int sel);
      return (sel == 1) ? 32 : (sel == 2) ? 16 : 64;
   endfunction

   function automatic int model_free();
      int base;
      base = (m_fc >= WIN) ? m_rp : m_sp;
      return DEPTH - (m_wp - base);
   endfunction

   function automatic int exp_req();
      return (model_free() >= thr_of(int'(thr_sel))) ? 1 : 0;
   endfunction

   task automatic wr_one(input logic [7:0] d, input logic eof);
      wr_en = 1'b1; wr_data = d; wr_eof = eof;
      @(negedge clk);
      wr_en = 1'b0; wr_eof = 1'b0;
   endtask

   task automatic rd_one();
      chk("R3 data", int'(rd_data), int'(sb[m_rp][7:0]));
      chk("R3 eof", int'(rd_eof), int'(sb[m_rp][8]));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      m_rp++;
      if (m_fc < WIN) m_fc++;
      @(negedge clk);
      chk((m_fc >= WIN) ? "R6 dreq live pointer" : "R5 dreq saved pointer",
          int'(dreq), exp_req());
   endtask

   task automatic retry();
      bit inside_win;
      inside_win = (m_fc < WIN);
      frame_retry = 1'b1;
      @(negedge clk);
      frame_retry = 1'b0;
      if (inside_win) begin m_rp = m_sp; m_fc = 0; end
      @(negedge clk);
      chk(inside_win ? "R7 rewind data" : "R8 late retry data",
          int'(rd_data), int'(sb[m_rp][7:0]));
      chk(inside_win ? "R7 dreq" : "R8 dreq", int'(dreq), exp_req());
   endtask

   task automatic fdone();
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
      m_sp = m_rp; m_fc = 0;
      @(negedge clk);
      chk("R9 dreq after done", int'(dreq), exp_req());
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rd_valid in reset", int'(rd_valid), 0);
      chk("R1 ovf in reset", int'(ovf), 0);
      chk("R1 dreq in reset", int'(dreq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 dreq after release", int'(dreq), 1);

      // Fill sweep: every fill level against every threshold code.
      for (int k = 0; k <= DEPTH; k++) begin
         for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            @(negedge clk);
            chk("R2 threshold sweep", int'(dreq), exp_req());
         end
         if (k < DEPTH) begin
            sb[m_wp] = {(k % 10 == 9), 8'(k)};
            wr_one(8'(k), (k % 10 == 9));
            chk("R11 one-cycle latency", int'(dreq), exp_req());
            m_wp++;
         end
      end

      wr_one(8'hAA, 1'b0);
      chk("R4 ovf set", int'(ovf), 1);
      @(negedge clk);
      chk("R4 dreq still zero when full", int'(dreq), 0);

      thr_sel = 2'b10;
      @(negedge clk);
      for (int i = 0; i < 20; i++) rd_one();
      retry();
      for (int i = 0; i < 60; i++) rd_one();
      retry();
      fdone();
      for (int i = 0; i < 10; i++) rd_one();
      thr_sel = 2'b00;
      @(negedge clk);
      chk("R5 free from saved before done", int'(dreq), exp_req());
      fdone();
      thr_sel = 2'b10;
      while (m_rp < m_wp) rd_one();
      chk("R3 drained rd_valid", int'(rd_valid), 0);
      chk("R4 ovf stays set", int'(ovf), 1);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
      chk("R3 read when empty ignored", int'(rd_valid), 0);
      fdone();

      // Second pass crosses the pointer wrap.
      thr_sel = 2'b00;
      for (int i = 0; i < 30; i++) begin
         sb[m_wp] = {(i == 29), 8'(200 + i)};
         wr_one(8'(200 + i), (i == 29));
         m_wp++;
      end
      @(negedge clk);
      chk("R10 dreq after frame loaded", int'(dreq), exp_req());
      chk("R10 dreq held high", int'(dreq), 1);
      for (int i = 0; i < 5; i++) rd_one();
      retry();
      chk("R7 rewind across wrap", int'(rd_data), 200);
      while (m_rp < m_wp) rd_one();
      fdone();
      chk("R9 all space released", int'(dreq), 1);
      chk("R4 ovf sticky to end", int'(ovf), 1);
      finish_run();
   end
endmodule